// File: doc/BRIEF.md
# Line-Cycle Gated Energy Accumulator

This block adds a stream of unsigned power samples into an energy total over a window of a set number of half line cycles. It places the window edges on zero crossings of the line. A zero-crossing pulse marks each half cycle. A 16-bit count register sets the window length. Each time the window closes, the running sum is copied into a readable line-energy register. The next window then opens on that same crossing, so calibration software gets back-to-back totals over whole numbers of half cycles.

Writing the count register does three things. It clears the line-energy register, drops any partial sum, and arms the block so that the next zero crossing opens a new window. The first end-of-cycle result after a write therefore covers a full window. Each close sets a sticky end-of-cycle flag. The flag drives the interrupt request only while the interrupt enable is high. Software clears the flag by writing a one to it. The block has no enable of its own. A count of zero keeps it idle.

Top module: `lcyc_energy_acc`

## Requirements
- R1: Reset (rst_n low at a clock edge) sets line_energy to 0, eoc_flag to 0, irq to 0 and the stored half-cycle count to 0, which is idle.
- R2: Each cycle with zx_pulse high counts as one half cycle. With a stored count N (1 to 65535), a window that opens on a crossing closes on the Nth crossing after it.
- R3: A cycle with ncyc_we high stores ncyc_wdata and clears line_energy to 0, visible after that clock edge. Any partial sum is discarded.
- R4: After a count write, accumulation begins only at the next zero crossing. Samples between the write and that crossing are not counted, and a crossing in the same cycle as the write is ignored.
- R5: When a window closes, line_energy takes the sum of smp_pwr over all cycles with smp_vld high, from the opening crossing's cycle up to the cycle before the closing crossing. eoc_flag is 1 after that edge.
- R6: The closing crossing opens the next window at once. A sample valid in the cycle of a crossing counts toward the window that the crossing opens.
- R7: eoc_flag stays 1 until a cycle with eoc_w1c high clears it. A window close in the same cycle as eoc_w1c leaves it set.
- R8: irq equals eoc_flag AND irq_en. Raising irq_en while the flag is set raises irq, and dropping irq_en lowers it.
- R9: line_energy changes only on a count write or a window close.
- R10: While the stored count is 0, no window opens or closes, eoc_flag is never set and line_energy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Power sample strobe |
| smp_pwr | input | 24 | Unsigned power sample |
| zx_pulse | input | 1 | Zero-crossing pulse, one cycle per crossing |
| ncyc_we | input | 1 | Write strobe for the half-cycle count |
| ncyc_wdata | input | 16 | Half-cycle count value to write |
| eoc_w1c | input | 1 | Write of a one to the end-of-cycle flag (clears it) |
| irq_en | input | 1 | End-of-cycle interrupt enable |
| line_energy | output | 48 | Energy latched at the last window close |
| eoc_flag | output | 1 | Sticky end-of-cycle status flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a window at the top count of 65535 half cycles. It has to close on exactly the last crossing with the correct sum, and the half-cycle counter must not wrap early. The bench reaches it by writing 65535 and then pulsing a crossing and a unit sample on every cycle, so the expected total equals the count. It checks that the flag is still clear one crossing before the close. Same-cycle collisions are driven on purpose from the vector table: a write with a crossing, a close with a clear, and a crossing with a sample.

// File: rtl/lce_pkg.sv
// Package: shared parameters and types for the line-cycle energy accumulator.
// Assumes all users compile it before any module of the block.
package lce_pkg;
    localparam int LCE_CNT_W = 16;   // half-cycle count width
    localparam int LCE_PWR_W = 24;   // power sample width
    localparam int LCE_ACC_W = 48;   // accumulator / line energy width

    // Window sequencing state: waiting for an opening crossing, or inside a window
    typedef enum logic [0:0] {
        WS_WAIT = 1'b0,
        WS_RUN  = 1'b1
    } win_state_t;
endpackage

// File: rtl/lce_window_ctrl.sv
// Module: lce_window_ctrl
// Holds the programmed half-cycle count and tracks crossings to produce
// one-cycle window open and close strobes. A count write has priority over a
// crossing in the same cycle and re-arms the block to wait for the next crossing.
// Assumes zx_pulse is a single-cycle strobe per crossing.
module lce_window_ctrl
    import lce_pkg::*;
#(
    parameter int CNT_W = LCE_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zx_pulse,
    input  logic             ncyc_we,
    input  logic [CNT_W-1:0] ncyc_wdata,
    output logic             win_open,
    output logic             win_close,
    output logic             win_run,
    output logic [CNT_W-1:0] ncyc_q
);
    win_state_t       ws_q;
    logic [CNT_W-1:0] hc_cnt_q;
    logic             idle;
    logic             last_hc;

    // Decode idle count, last half cycle and the window strobes
    always_comb begin
        idle      = (ncyc_q == '0);
        last_hc   = (hc_cnt_q == ncyc_q - CNT_W'(1));
        win_open  = !ncyc_we && zx_pulse && (ws_q == WS_WAIT) && !idle;
        win_close = !ncyc_we && zx_pulse && (ws_q == WS_RUN) && last_hc;
        win_run   = (ws_q == WS_RUN);
    end

    // Count register, window state and half-cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ncyc_q   <= '0;
            ws_q     <= WS_WAIT;
            hc_cnt_q <= '0;
        end else if (ncyc_we) begin
            ncyc_q   <= ncyc_wdata;
            ws_q     <= WS_WAIT;
            hc_cnt_q <= '0;
        end else if (zx_pulse && (ws_q == WS_RUN)) begin
            hc_cnt_q <= last_hc ? '0 : hc_cnt_q + CNT_W'(1);
        end else if (win_open) begin
            ws_q     <= WS_RUN;
            hc_cnt_q <= '0;
        end
    end
endmodule

// File: rtl/lce_accum.sv
// Module: lce_accum
// Sums valid power samples during a window and copies the running sum into
// the readable line-energy register at each close. A sample in a crossing
// cycle seeds the window that crossing opens. Sums wrap modulo 2**ACC_W.
// Assumes ACC_W > PWR_W.
module lce_accum
    import lce_pkg::*;
#(
    parameter int PWR_W = LCE_PWR_W,
    parameter int ACC_W = LCE_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [PWR_W-1:0] smp_pwr,
    input  logic             clr_all,
    input  logic             win_open,
    input  logic             win_close,
    input  logic             win_run,
    output logic [ACC_W-1:0] line_energy
);
    localparam int PAD_W = ACC_W - PWR_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] add_term;

    // Extend the sample to accumulator width, zero when not valid
    always_comb begin
        add_term = smp_vld ? {{PAD_W{1'b0}}, smp_pwr} : '0;
    end

    // Running sum and latched line energy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= '0;
            line_energy <= '0;
        end else if (clr_all) begin
            acc_q       <= '0;
            line_energy <= '0;
        end else if (win_open || win_close) begin
            acc_q <= add_term;
            if (win_close) begin
                line_energy <= acc_q;
            end
        end else if (win_run) begin
            acc_q <= acc_q + add_term;
        end
    end
endmodule

// File: rtl/lce_status.sv
// Module: lce_status
// Sticky end-of-cycle flag, set by a window close and cleared by a write of
// one; a close wins over a clear in the same cycle. Gates the flag with the
// interrupt enable to form the request.
module lce_status (
    input  logic clk,
    input  logic rst_n,
    input  logic win_close,
    input  logic eoc_w1c,
    input  logic irq_en,
    output logic eoc_flag,
    output logic irq
);
    // Flag set / clear with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_flag <= 1'b0;
        end else if (win_close) begin
            eoc_flag <= 1'b1;
        end else if (eoc_w1c) begin
            eoc_flag <= 1'b0;
        end
    end

    // Interrupt request follows the enabled flag
    always_comb begin
        irq = eoc_flag && irq_en;
    end
endmodule

// File: rtl/lcyc_energy_acc.sv
// Module: lcyc_energy_acc (top)
// Accumulates power samples over a programmed number of half line cycles,
// aligned to zero crossings, and reports each completed window through a
// latched energy register, a sticky flag and an interrupt request.
// Assumes inputs are synchronous to clk; always active, a count of 0 is idle.
module lcyc_energy_acc
    import lce_pkg::*;
#(
    parameter int CNT_W = LCE_CNT_W,
    parameter int PWR_W = LCE_PWR_W,
    parameter int ACC_W = LCE_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [PWR_W-1:0] smp_pwr,
    input  logic             zx_pulse,
    input  logic             ncyc_we,
    input  logic [CNT_W-1:0] ncyc_wdata,
    input  logic             eoc_w1c,
    input  logic             irq_en,
    output logic [ACC_W-1:0] line_energy,
    output logic             eoc_flag,
    output logic             irq
);
    logic             win_open;
    logic             win_close;
    logic             win_run;
    logic [CNT_W-1:0] ncyc_q;

    lce_window_ctrl #(.CNT_W(CNT_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .zx_pulse   (zx_pulse),
        .ncyc_we    (ncyc_we),
        .ncyc_wdata (ncyc_wdata),
        .win_open   (win_open),
        .win_close  (win_close),
        .win_run    (win_run),
        .ncyc_q     (ncyc_q)
    );

    lce_accum #(.PWR_W(PWR_W), .ACC_W(ACC_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .smp_pwr     (smp_pwr),
        .clr_all     (ncyc_we),
        .win_open    (win_open),
        .win_close   (win_close),
        .win_run     (win_run),
        .line_energy (line_energy)
    );

    lce_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_close (win_close),
        .eoc_w1c   (eoc_w1c),
        .irq_en    (irq_en),
        .eoc_flag  (eoc_flag),
        .irq       (irq)
    );
endmodule

// File: rtl/lce_chk.sv
// Module: lce_chk
// Assertion checker for lcyc_energy_acc, attached by bind below.
module lce_chk #(
    parameter int CNT_W = 16,
    parameter int ACC_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             zx_pulse,
    input logic             ncyc_we,
    input logic             eoc_w1c,
    input logic             win_open,
    input logic             win_close,
    input logic [CNT_W-1:0] ncyc_q,
    input logic [ACC_W-1:0] line_energy,
    input logic             eoc_flag
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (line_energy == '0) && !eoc_flag && (ncyc_q == '0)); // R1

    AST_CLOSE_ON_CROSSING: assert property (@(posedge clk) disable iff (!rst_n)
        win_close |-> zx_pulse); // R2

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ncyc_we |=> (line_energy == '0)); // R3

    AST_WRITE_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ncyc_we |-> !win_open && !win_close); // R4

    AST_FLAG_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_close |=> eoc_flag); // R5

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_flag) |-> $past(win_close)); // R5

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_flag && !eoc_w1c |=> eoc_flag); // R7

    AST_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ncyc_we && !win_close |=> $stable(line_energy)); // R9

    AST_IDLE_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ncyc_q == '0) |-> !win_open && !win_close); // R10
endmodule

bind lcyc_energy_acc lce_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .zx_pulse    (zx_pulse),
    .ncyc_we     (ncyc_we),
    .eoc_w1c     (eoc_w1c),
    .win_open    (win_open),
    .win_close   (win_close),
    .ncyc_q      (ncyc_q),
    .line_energy (line_energy),
    .eoc_flag    (eoc_flag)
);

// File: tb/sim_lcyc_energy_acc.sv
// Bench for lcyc_energy_acc: vector table walk, then directed corner tests.
module sim_lcyc_energy_acc;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 150000;

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [15:0] wd;
        logic        zc;
        logic        vld;
        logic [23:0] pwr;
        logic        w1c;
        logic        en;
        logic [31:0] e_energy;
        logic        e_eoc;
        logic        e_irq;
    } vec_t;

    localparam int NV = 21;
    // req, we, wd, zc, vld, pwr, w1c, en, energy, eoc, irq
    localparam vec_t VEC [NV] = '{
        '{4'd4, 1'b1, 16'd2, 1'b1, 1'b1, 24'd5,   1'b0, 1'b0, 32'd0,   1'b0, 1'b0}, // R4 crossing with write ignored
        '{4'd4, 1'b0, 16'd0, 1'b0, 1'b1, 24'd7,   1'b0, 1'b0, 32'd0,   1'b0, 1'b0}, // R4 sample before opening dropped
        '{4'd4, 1'b0, 16'd0, 1'b1, 1'b1, 24'd3,   1'b0, 1'b0, 32'd0,   1'b0, 1'b0}, // R4 window opens, acc 3
        '{4'd9, 1'b0, 16'd0, 1'b0, 1'b1, 24'd10,  1'b0, 1'b0, 32'd0,   1'b0, 1'b0}, // R9 acc 13, output stable
        '{4'd2, 1'b0, 16'd0, 1'b1, 1'b0, 24'd0,   1'b0, 1'b0, 32'd0,   1'b0, 1'b0}, // R2 first half cycle
        '{4'd9, 1'b0, 16'd0, 1'b0, 1'b1, 24'd4,   1'b0, 1'b0, 32'd0,   1'b0, 1'b0}, // R9 acc 17
        '{4'd5, 1'b0, 16'd0, 1'b1, 1'b1, 24'd100, 1'b0, 1'b0, 32'd17,  1'b1, 1'b0}, // R5 close, 17
        '{4'd8, 1'b0, 16'd0, 1'b0, 1'b0, 24'd0,   1'b0, 1'b1, 32'd17,  1'b1, 1'b1}, // R8 enable raises irq
        '{4'd7, 1'b0, 16'd0, 1'b0, 1'b0, 24'd0,   1'b1, 1'b1, 32'd17,  1'b0, 1'b0}, // R7 write-one clears
        '{4'd9, 1'b0, 16'd0, 1'b0, 1'b1, 24'd1,   1'b0, 1'b1, 32'd17,  1'b0, 1'b0}, // R9 acc 101
        '{4'd2, 1'b0, 16'd0, 1'b1, 1'b0, 24'd0,   1'b0, 1'b1, 32'd17,  1'b0, 1'b0}, // R2 one half cycle
        '{4'd6, 1'b0, 16'd0, 1'b1, 1'b1, 24'd2,   1'b1, 1'b1, 32'd101, 1'b1, 1'b1}, // R6 seed 100 counted; R7 set wins
        '{4'd8, 1'b0, 16'd0, 1'b0, 1'b0, 24'd0,   1'b0, 1'b0, 32'd101, 1'b1, 1'b0}, // R8 disable drops irq
        '{4'd2, 1'b0, 16'd0, 1'b1, 1'b0, 24'd0,   1'b0, 1'b0, 32'd101, 1'b1, 1'b0}, // R2 half cycle
        '{4'd3, 1'b1, 16'd3, 1'b1, 1'b0, 24'd0,   1'b0, 1'b0, 32'd0,   1'b1, 1'b0}, // R3 write clears energy
        '{4'd4, 1'b0, 16'd0, 1'b0, 1'b1, 24'd9,   1'b0, 1'b0, 32'd0,   1'b1, 1'b0}, // R4 dropped sample
        '{4'd4, 1'b0, 16'd0, 1'b1, 1'b1, 24'd1,   1'b0, 1'b0, 32'd0,   1'b1, 1'b0}, // R4 opens, acc 1
        '{4'd2, 1'b0, 16'd0, 1'b1, 1'b0, 24'd0,   1'b0, 1'b0, 32'd0,   1'b1, 1'b0}, // R2 1 of 3
        '{4'd2, 1'b0, 16'd0, 1'b1, 1'b0, 24'd0,   1'b0, 1'b0, 32'd0,   1'b1, 1'b0}, // R2 2 of 3
        '{4'd5, 1'b0, 16'd0, 1'b1, 1'b1, 24'd6,   1'b0, 1'b0, 32'd1,   1'b1, 1'b0}, // R5 close after 3
        '{4'd7, 1'b0, 16'd0, 1'b0, 1'b0, 24'd0,   1'b1, 1'b0, 32'd1,   1'b0, 1'b0}  // R7 clear
    };

    logic        clk = 1'b0;
    logic        rst_n, smp_vld, zx_pulse, ncyc_we, eoc_w1c, irq_en;
    logic [23:0] smp_pwr;
    logic [15:0] ncyc_wdata;
    logic [47:0] line_energy;
    logic        eoc_flag, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcyc_energy_acc u0 (
        .clk (clk), .rst_n (rst_n), .smp_vld (smp_vld), .smp_pwr (smp_pwr),
        .zx_pulse (zx_pulse), .ncyc_we (ncyc_we), .ncyc_wdata (ncyc_wdata),
        .eoc_w1c (eoc_w1c), .irq_en (irq_en), .line_energy (line_energy),
        .eoc_flag (eoc_flag), .irq (irq)
    );

    // Apply one cycle of inputs at the falling edge, return after the next rise
    task automatic cyc(input logic we, input logic [15:0] wd, input logic zc,
                       input logic vld, input logic [23:0] pwr,
                       input logic w1c, input logic en);
        @(negedge clk);
        ncyc_we = we; ncyc_wdata = wd; zx_pulse = zc;
        smp_vld = vld; smp_pwr = pwr; eoc_w1c = w1c; irq_en = en;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [47:0] e_en,
                         input logic e_eoc, input logic e_irq);
        n_chk++;
        if (line_energy !== e_en || eoc_flag !== e_eoc || irq !== e_irq) begin
            n_bad++;
            $display("FAIL %s: energy %0d exp %0d, eoc %0b exp %0b, irq %0b exp %0b",
                     tag, line_energy, e_en, eoc_flag, e_eoc, irq, e_irq);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; smp_vld = 1'b0; smp_pwr = '0; zx_pulse = 1'b0;
        ncyc_we = 1'b0; ncyc_wdata = '0; eoc_w1c = 1'b0; irq_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 48'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset the count is 0, so crossings open nothing
        repeat (3) cyc(1'b0, 16'd0, 1'b1, 1'b1, 24'd9, 1'b0, 1'b1);
        check("R1 idle after reset", 48'd0, 1'b0, 1'b0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].we, VEC[i].wd, VEC[i].zc, VEC[i].vld, VEC[i].pwr,
                VEC[i].w1c, VEC[i].en);
            check($sformatf("R%0d vec %0d", VEC[i].req, i),
                  {16'd0, VEC[i].e_energy}, VEC[i].e_eoc, VEC[i].e_irq);
        end

        // R10: count 0 stays idle under crossings and samples
        cyc(1'b1, 16'd0, 1'b0, 1'b0, 24'd0, 1'b0, 1'b1);
        for (int i = 0; i < 20; i++) cyc(1'b0, 16'd0, 1'b1, 1'b1, 24'd50, 1'b0, 1'b1);
        check("R10 idle count", 48'd0, 1'b0, 1'b0);

        // R2: one half cycle window, wide samples
        cyc(1'b1, 16'd1, 1'b0, 1'b0, 24'd0, 1'b0, 1'b0);
        cyc(1'b0, 16'd0, 1'b1, 1'b1, 24'hFFFFFF, 1'b0, 1'b0);
        cyc(1'b0, 16'd0, 1'b0, 1'b1, 24'hFFFFFF, 1'b0, 1'b0);
        check("R2 N=1 before close", 48'd0, 1'b0, 1'b0);
        cyc(1'b0, 16'd0, 1'b1, 1'b0, 24'd0, 1'b0, 1'b0);
        check("R2 N=1 close", 48'h1FFFFFE, 1'b1, 1'b0);

        // R1: reset mid-operation clears outputs and the count
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid-run", 48'd0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) cyc(1'b0, 16'd0, 1'b1, 1'b1, 24'd3, 1'b0, 1'b0);
        check("R1 count idle after reset", 48'd0, 1'b0, 1'b0);

        // R2: maximum count, crossing and unit sample every cycle
        cyc(1'b1, 16'd65535, 1'b0, 1'b0, 24'd0, 1'b0, 1'b1);
        cyc(1'b0, 16'd0, 1'b1, 1'b1, 24'd1, 1'b0, 1'b1);
        for (int i = 1; i < 65535; i++) cyc(1'b0, 16'd0, 1'b1, 1'b1, 24'd1, 1'b0, 1'b1);
        check("R2 max count one short", 48'd0, 1'b0, 1'b0);
        cyc(1'b0, 16'd0, 1'b1, 1'b1, 24'd1, 1'b0, 1'b1);
        check("R2 max count close", 48'd65535, 1'b1, 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule